// File: doc/BRIEF.md
# I2C Slave Receive Capture

This block is the receive half of a serial port that runs as a clock slave on an I2C bus. An external master drives SCL. The block samples SDA on each rising SCL edge and shifts in eight data bits, most significant first. It then takes a ninth, acknowledge bit. Completed bytes go into a 16-bit receive buffer. At the point in the frame that the mode inputs choose, the block raises single-cycle strobes for interrupts and DMA. Start and stop detection, acknowledge driving and master clocking are handled elsewhere.

Two static mode inputs shape the frame. `irq_sel` selects where the interrupt falls:
- At 0, an ACK or NACK strobe follows the ninth bit, and the ACK strobe doubles as the DMA request.
- At 1, receive and transmit strobes follow the eighth bit, and the transmit strobe is the DMA request.

`clk_delay` moves each buffer load from the rising SCL edge of its bit to the following falling edge. With `irq_sel` at 1, it also adds a second, silent load after the ninth bit that writes the acknowledge level into buffer bit 8.

The controller is a four-state machine:
- SHIFT: collects data bits. On the eighth rising edge it goes to HOLD_BYTE when both mode bits are 1, and to ACK_BIT otherwise.
- HOLD_BYTE: waits for the falling SCL edge, loads the byte, then goes to ACK_BIT.
- ACK_BIT: takes the ninth rising edge. It goes to HOLD_ACK when `clk_delay` is 1, and back to SHIFT otherwise.
- HOLD_ACK: waits for the falling SCL edge, then returns to SHIFT.

Top module: `i2c_slave_rx_capture`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `rx_buf` to 0, holds every strobe low, and restarts the bit count, so the next rising SCL edge is taken as data bit 7.
- R2: SCL and SDA each pass through two flip-flops. SDA is sampled on each rising SCL edge, and the first eight samples land in `rx_buf[7:0]` with the first-received bit at bit 7.
- R3: With `irq_sel`=0, a ninth-bit SDA level of 0 (ACK) produces a one-cycle `ack_irq` with `dma_req` high in the same cycle.
- R4: With `irq_sel`=0, a ninth-bit SDA level of 1 (NACK) produces a one-cycle `nack_irq`, with `ack_irq` and `dma_req` low.
- R5: With `irq_sel`=0, `rx_buf` becomes {ACK level in bit 8, data in bits 7..0} in the same cycle as the strobe. The load happens after the ninth rising SCL edge when `clk_delay`=0, and only after the following falling edge when `clk_delay`=1.
- R6: With `irq_sel`=1 and `clk_delay`=0, the eighth rising SCL edge loads `rx_buf` with {0 in bit 8, data in 7..0} and pulses `rx_irq`, `tx_irq` and `dma_req` together. The ninth bit changes nothing.
- R7: With `irq_sel`=1 and `clk_delay`=1, the load and the three strobes of R6 wait for the falling SCL edge after the eighth bit. The falling edge after the ninth bit then writes the ACK level into bit 8, keeps bits 7..0, and raises no strobe.
- R8: `rx_buf[15:9]` is always 0.
- R9: Every strobe lasts one clock cycle. `ack_irq` and `nack_irq` are never high together.
- R10: The bit count returns to zero after the ninth bit, so back-to-back frames decode independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Bus clock driven by the master |
| sda_in | input | 1 | Bus data line |
| irq_sel | input | 1 | 0: ACK/NACK strobe after bit 9; 1: receive/transmit strobes after bit 8 |
| clk_delay | input | 1 | 1: loads move to the falling SCL edge |
| rx_buf | output | 16 | Receive buffer |
| ack_irq | output | 1 | Acknowledge strobe |
| nack_irq | output | 1 | Not-acknowledge strobe |
| rx_irq | output | 1 | Receive strobe |
| tx_irq | output | 1 | Transmit strobe |
| dma_req | output | 1 | DMA request strobe |

## Verification
The hardest case to reach from the ports is the delayed mode with `irq_sel`=1. There, a correct strobe and a silent second buffer write arrive on two different falling edges. The strobe scoreboard cannot see the silent write, and the strobe itself lands only a few clocks after a no-delay design would have fired. To expose both, the stimulus holds SCL high for several clocks after the eighth and ninth rising edges and counts strobes at that moment. It then reads `rx_buf` after the frame ends and expects the acknowledge level in bit 8.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

    typedef enum logic [1:0] {
        ST_SHIFT     = 2'd0,
        ST_HOLD_BYTE = 2'd1,
        ST_ACK_BIT   = 2'd2,
        ST_HOLD_ACK  = 2'd3
    } rx_state_e;

endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/i2c_rx_edge.sv
module i2c_rx_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise,
    output logic fall
);

    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;

endmodule

// File: rtl/i2c_rx_fsm.sv
module i2c_rx_fsm
    import i2c_rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 sda,
    input  logic                 irq_sel,
    input  logic                 clk_delay,
    output logic                 ev_byte,
    output logic                 ev_ack,
    output logic [DATA_BITS-1:0] ev_data,
    output logic                 ev_ackbit
);

    localparam int CNT_W = $clog2(DATA_BITS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_BITS - 1);

    rx_state_e             state, nxt;
    logic [CNT_W-1:0]      cnt;
    logic [DATA_BITS-1:0]  shreg;
    logic                  ack_q;

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_SHIFT:
                if (scl_rise && cnt == LAST)
                    nxt = (irq_sel && clk_delay) ? ST_HOLD_BYTE : ST_ACK_BIT;
            ST_HOLD_BYTE:
                if (scl_fall) nxt = ST_ACK_BIT;
            ST_ACK_BIT:
                if (scl_rise) nxt = clk_delay ? ST_HOLD_ACK : ST_SHIFT;
            ST_HOLD_ACK:
                if (scl_fall) nxt = ST_SHIFT;
            default: nxt = ST_SHIFT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_SHIFT;
        else     state <= nxt;
    end

    // datapath: shift register, bit counter, acknowledge capture
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            shreg <= '0;
            ack_q <= 1'b0;
        end else if (scl_rise) begin
            if (state == ST_SHIFT) begin
                shreg <= {shreg[DATA_BITS-2:0], sda};
                cnt   <= cnt + 1'b1;
            end else if (state == ST_ACK_BIT) begin
                ack_q <= sda;
                cnt   <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        ev_byte   = 1'b0;
        ev_ack    = 1'b0;
        ev_data   = shreg;
        ev_ackbit = ack_q;
        unique case (state)
            ST_SHIFT: begin
                ev_data = {shreg[DATA_BITS-2:0], sda};
                ev_byte = scl_rise && (cnt == LAST) && irq_sel && !clk_delay;
            end
            ST_HOLD_BYTE:
                ev_byte = scl_fall;
            ST_ACK_BIT: begin
                ev_ackbit = sda;
                ev_ack    = scl_rise && !clk_delay;
            end
            ST_HOLD_ACK:
                ev_ack = scl_fall;
            default: ;
        endcase
    end

    a_r10_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DATA_BITS));
    a_r10_wrap: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACK_BIT && scl_rise) |=> (cnt == '0));
    a_r1_reset_restart: assert property (@(posedge clk)
        rst |=> (cnt == '0 && state == ST_SHIFT));

endmodule

// File: rtl/i2c_rx_buf.sv
module i2c_rx_buf #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 irq_sel,
    input  logic                 clk_delay,
    input  logic                 ev_byte,
    input  logic                 ev_ack,
    input  logic [DATA_BITS-1:0] ev_data,
    input  logic                 ev_ackbit,
    output logic [DATA_BITS:0]   buf_q,
    output logic                 ack_irq,
    output logic                 nack_irq,
    output logic                 rx_irq,
    output logic                 tx_irq,
    output logic                 dma_req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q    <= '0;
            ack_irq  <= 1'b0;
            nack_irq <= 1'b0;
            rx_irq   <= 1'b0;
            tx_irq   <= 1'b0;
            dma_req  <= 1'b0;
        end else begin
            ack_irq  <= 1'b0;
            nack_irq <= 1'b0;
            rx_irq   <= 1'b0;
            tx_irq   <= 1'b0;
            dma_req  <= 1'b0;
            if (ev_byte) begin
                buf_q   <= {1'b0, ev_data};
                rx_irq  <= 1'b1;
                tx_irq  <= 1'b1;
                dma_req <= 1'b1;
            end else if (ev_ack) begin
                if (!irq_sel) begin
                    buf_q    <= {ev_ackbit, ev_data};
                    ack_irq  <= !ev_ackbit;
                    nack_irq <= ev_ackbit;
                    dma_req  <= !ev_ackbit;
                end else if (clk_delay) begin
                    buf_q[DATA_BITS] <= ev_ackbit;
                end
            end
        end
    end

    a_r9_rx_pulse: assert property (@(posedge clk) disable iff (rst)
        rx_irq |=> !rx_irq);
    a_r9_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        (ack_irq || nack_irq) |=> !(ack_irq || nack_irq));
    a_r9_ack_nack_excl: assert property (@(posedge clk) disable iff (rst)
        !(ack_irq && nack_irq));
    a_r3_dma_with_ack: assert property (@(posedge clk) disable iff (rst)
        ack_irq |-> dma_req);
    a_r4_nack_no_dma: assert property (@(posedge clk) disable iff (rst)
        nack_irq |-> !dma_req);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (buf_q == '0 && !rx_irq && !ack_irq && !nack_irq));

endmodule

// File: rtl/i2c_slave_rx_capture.sv
module i2c_slave_rx_capture #(
    parameter int DATA_BITS   = 8,
    parameter int BUF_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             irq_sel,
    input  logic             clk_delay,
    output logic [BUF_W-1:0] rx_buf,
    output logic             ack_irq,
    output logic             nack_irq,
    output logic             rx_irq,
    output logic             tx_irq,
    output logic             dma_req
);

    localparam int PAD_W = BUF_W - DATA_BITS - 1;

    logic [1:0]           sync_q;
    logic                 scl_rise, scl_fall;
    logic                 ev_byte, ev_ack, ev_ackbit;
    logic [DATA_BITS-1:0] ev_data;
    logic [DATA_BITS:0]   buf_q;

    i2c_rx_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_in, sda_in}),
        .q   (sync_q)
    );

    i2c_rx_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (sync_q[1]),
        .rise (scl_rise),
        .fall (scl_fall)
    );

    i2c_rx_fsm #(.DATA_BITS(DATA_BITS)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda       (sync_q[0]),
        .irq_sel   (irq_sel),
        .clk_delay (clk_delay),
        .ev_byte   (ev_byte),
        .ev_ack    (ev_ack),
        .ev_data   (ev_data),
        .ev_ackbit (ev_ackbit)
    );

    i2c_rx_buf #(.DATA_BITS(DATA_BITS)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .irq_sel   (irq_sel),
        .clk_delay (clk_delay),
        .ev_byte   (ev_byte),
        .ev_ack    (ev_ack),
        .ev_data   (ev_data),
        .ev_ackbit (ev_ackbit),
        .buf_q     (buf_q),
        .ack_irq   (ack_irq),
        .nack_irq  (nack_irq),
        .rx_irq    (rx_irq),
        .tx_irq    (tx_irq),
        .dma_req   (dma_req)
    );

    assign rx_buf = {{PAD_W{1'b0}}, buf_q};

    a_r8_upper_zero: assert property (@(posedge clk) disable iff (rst)
        rx_buf[BUF_W-1:DATA_BITS+1] == '0);
    a_r6_rx_tx_dma_pair: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> (tx_irq && dma_req && !ack_irq && !nack_irq));

endmodule

// File: tb/test_i2c_slave_rx_capture.sv
module test_i2c_slave_rx_capture;

    typedef struct packed {
        logic [4:0]  flags;   // {ack, nack, rx, tx, dma}
        logic [15:0] bufv;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b0;
    logic        sda = 1'b1;
    logic        irq_sel = 1'b0;
    logic        clk_delay = 1'b0;
    logic [15:0] rx_buf;
    logic        ack_irq, nack_irq, rx_irq, tx_irq, dma_req;

    int n_checks = 0;
    int n_fail   = 0;
    int n_strobe = 0;
    bit done     = 1'b0;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    i2c_slave_rx_capture i_i2c_slave_rx_capture (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl),
        .sda_in    (sda),
        .irq_sel   (irq_sel),
        .clk_delay (clk_delay),
        .rx_buf    (rx_buf),
        .ack_irq   (ack_irq),
        .nack_irq  (nack_irq),
        .rx_irq    (rx_irq),
        .tx_irq    (tx_irq),
        .dma_req   (dma_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && (ack_irq || nack_irq || rx_irq || tx_irq || dma_req)) begin
            exp_t e;
            n_strobe++;
            if (exp_q.size() == 0) begin
                check("R9 unexpected strobe", {27'd0, ack_irq, nack_irq, rx_irq, tx_irq, dma_req}, 32'd0);
            end else begin
                e = exp_q.pop_front();
                check("R3/R4/R6 strobe set", {27'd0, ack_irq, nack_irq, rx_irq, tx_irq, dma_req}, {27'd0, e.flags});
                check("R2/R5/R6 buffer at strobe", {16'd0, rx_buf}, {16'd0, e.bufv});
            end
        end
    end

    // one bit; when chk_rise, counts strobes after the rising edge with SCL still high
    task automatic send_bit(input logic v, input bit chk_rise, input int exp_inc, input string req);
        int snap;
        sda = v;
        clocks(4);
        snap = n_strobe;
        scl = 1'b1;
        clocks(6);
        if (chk_rise) check(req, n_strobe - snap, exp_inc);
        clocks(2);
        scl = 1'b0;
        clocks(4);
    endtask

    task automatic send_frame(input logic m, input logic d, input logic [7:0] data, input logic ackb);
        exp_t e;
        logic [15:0] final_buf;
        irq_sel   = m;
        clk_delay = d;
        if (m) begin
            e.flags = 5'b00111;
            e.bufv  = {8'd0, data};
        end else begin
            e.flags = ackb ? 5'b01000 : 5'b10001;
            e.bufv  = {7'd0, ackb, data};
        end
        exp_q.push_back(e);
        for (int i = 7; i >= 0; i--)
            send_bit(data[i], i == 0, (m && !d) ? 1 : 0, "R6/R7 eighth-bit timing");
        send_bit(ackb, 1'b1, (!m && !d) ? 1 : 0, "R5/R7 ninth-bit timing");
        clocks(4);
        if (m && !d) final_buf = {8'd0, data};
        else         final_buf = {7'd0, ackb, data};
        check("R5/R6/R7/R8 buffer after frame", {16'd0, rx_buf}, {16'd0, final_buf});
        check("R10 scoreboard drained", exp_q.size(), 0);
    endtask

    initial begin
        #(200000 * 8);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        clocks(4);
        rst = 1'b0;
        clocks(2);
        // R1 reset state
        check("R1 reset buffer", {16'd0, rx_buf}, 32'd0);
        check("R1 reset strobes", {27'd0, ack_irq, nack_irq, rx_irq, tx_irq, dma_req}, 32'd0);

        send_frame(1'b0, 1'b0, 8'hA5, 1'b0);   // R3
        send_frame(1'b0, 1'b0, 8'h3C, 1'b1);   // R4
        send_frame(1'b0, 1'b1, 8'hFF, 1'b0);   // R5 delayed
        send_frame(1'b0, 1'b1, 8'h01, 1'b1);   // R5 delayed NACK
        send_frame(1'b1, 1'b0, 8'h81, 1'b1);   // R6
        send_frame(1'b1, 1'b1, 8'h5A, 1'b1);   // R7 ack level 1 into bit 8
        send_frame(1'b1, 1'b1, 8'h00, 1'b0);   // R7
        send_frame(1'b1, 1'b0, 8'h7E, 1'b0);   // R10 back-to-back

        // R1: reset mid-frame restarts the count
        irq_sel = 1'b0;
        clk_delay = 1'b0;
        for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0, 0, "");
        rst = 1'b1;
        clocks(2);
        rst = 1'b0;
        clocks(2);
        check("R1 mid-frame reset buffer", {16'd0, rx_buf}, 32'd0);
        send_frame(1'b0, 1'b0, 8'hC3, 1'b0);   // R1 R2 fresh count
        check("R8 upper bits zero", {16'd0, rx_buf[15:9]}, 32'd0);
        clocks(10);
        finish_run();
    end

endmodule